// File: doc/BRIEF.md
# Managed-NAND Card Bring-Up Sequencer

This block is a state machine that takes a managed-NAND memory card from power-on idle to a mounted, selected card that runs at its fastest supported timing and at the widest data bus. It does not serialise commands itself. For each step it presents a command index, a 32-bit argument and a data-phase flag to a separate command/data engine, then raises a one-cycle start strobe. It waits for the engine's completion strobe and judges the result from the error flag, the 128-bit response and the card-type byte of the extended register block.

Along the way it drives a clock-request code and a clock enable to the card-clock divider, and a bus-width code to the data path. Every delay is measured in system-clock cycles and derived from the `CLK_HZ` parameter. After a mount attempt the machine rests in `ST_MOUNTED` or `ST_FAILED` and shows an error code. A new `start` pulse in any resting state begins a fresh attempt.

States, in order: `ST_IDLE`, `ST_CLK_SETTLE` (1 ms), `ST_RESET_CMD`, `ST_RESET_GAP` (200 us), `ST_OP_COND`, `ST_OP_GAP` (1 ms), `ST_GET_ID`, `ST_SET_ADDR`, `ST_GET_CSD`, `ST_SELECT`, `ST_BLKLEN`, `ST_READ_EXT`, `ST_HS_SWITCH`, `ST_HS_STATUS`, `ST_BW_SWITCH`, `ST_BW_STATUS`, `ST_BW_REREAD`, `ST_MOUNTED`, `ST_FAILED`.

Transitions:
- A resting state goes to `ST_CLK_SETTLE` on `start`, or to `ST_FAILED` if a precondition is missing.
- Each wait state moves on when its timer expires.
- Each command state moves to the next state in the list when its command completes.
- `ST_OP_COND` loops through `ST_OP_GAP` while the card is not ready.
- `ST_READ_EXT` skips `ST_HS_SWITCH` when the card reports no high-speed support.
- Any failed check or engine error goes to `ST_FAILED`.

Top module: `mmc_mount_fsm`

## Requirements
- R1: A `start` pulse while `host_init` is low, while `card_pwr` is low, or while `eng_busy` is high ends in `mount_fail` with `err_code` 1 (state error), and no command is issued.
- R2: An accepted start enables the card clock with `clk_req` 0 (the ~400 kHz request) and waits at least 1 ms. It then issues command 0 with argument 0.
- R3: After command 0 completes there is a gap of at least 200 us before the first command 1. Command 1 carries the argument `HOST_OCR`, and consecutive command-1 tries are at least 1 ms apart.
- R4: Command 1 is repeated until response bit 31 (power-up done) is set, for at most `RETRY_MAX` (300) tries. A card that reports ready on the last try is accepted. If the bit never sets, the sequence ends with `err_code` 3 (timeout).
- R5: In the ready command-1 response, bits 30:29 must equal 2'b10 (sector access). Any other value ends the sequence with `err_code` 4.
- R6: The identification order is: command 2 with argument 0, then commands 3, 9 and 7, each with `RCA` in argument bits 31:16 and zeros below. The index and argument hold steady while a command is outstanding.
- R7: If the spec-version field in bits 125:122 of the command-9 response is below 4, the sequence ends with `err_code` 5 (illegal card). A value of 4 is accepted.
- R8: After command 7 the clock request becomes 1 (20 MHz). Then command 16 is issued with argument 512, followed by command 8 with argument 0 and `cmd_data` high. `cmd_data` is low for every other command.
- R9: Card-type bit 1 selects `clk_req` 3 (52 MHz) and bit 0 alone selects 2 (26 MHz). Either one first issues command 6 with argument 0x03B90100 and raises `hs_timing`. With neither bit set, no switch is issued and the request stays at 1. In both cases command 13 with the `RCA` argument follows.
- R10: The bus-width step issues command 6 with argument 0x03B70000 plus `BW_CODE` (2 = 8-bit, 1 = 4-bit, 0 = 1-bit) in bits 15:8, then command 13 and command 8. Success shows `bus_width` = `BW_CODE` and `mount_ok`. If the switch fails, `bus_width` is 0.
- R11: An engine error on any command ends the sequence with `err_code` 2 and `mount_fail`. Every failure other than a state error also drops `clk_en`.
- R12: Out of reset the block is idle: `busy`, `mount_ok`, `mount_fail`, `clk_en`, `cmd_start` and `bus_width` are all 0. `busy` is high exactly while a mount attempt is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a mount attempt (one-cycle pulse) |
| host_init | input | 1 | Host controller has been initialised |
| card_pwr | input | 1 | Card supply is on |
| eng_busy | input | 1 | Command engine reports the card line busy |
| cmd_start | output | 1 | One-cycle strobe to issue the presented command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_data | output | 1 | Command has a 512-byte read data phase |
| cmd_done | input | 1 | Engine completion strobe |
| cmd_err | input | 1 | Engine error, valid with `cmd_done` |
| resp | input | 128 | Response of the completed command (short responses in bits 31:0) |
| ext_card_type | input | 8 | Card-type byte of the extended register block |
| clk_en | output | 1 | Card clock enable |
| clk_req | output | 2 | Clock request: 0 ~400 kHz, 1 20 MHz, 2 26 MHz, 3 52 MHz |
| bus_width | output | 2 | Data bus width code: 0 1-bit, 1 4-bit, 2 8-bit |
| hs_timing | output | 1 | High-speed timing has been switched on |
| busy | output | 1 | Mount attempt in progress |
| mount_ok | output | 1 | Last attempt succeeded |
| mount_fail | output | 1 | Last attempt failed |
| err_code | output | 3 | 0 none, 1 state, 2 command, 3 timeout, 4 access mode, 5 illegal card |

## Verification
The embedded assertions check these on every cycle:
- a refused start ends in the state error without any command strobe;
- command 1 is only ever issued with the slow clock running;
- the retry counter never passes its bound;
- the bus-width output only ever holds 0 or the configured code;
- every non-state failure has the clock stopped;
- high-speed timing is never reported with the slow clock request;
- the presented index and argument stay steady while a command is outstanding;
- the wait timer counts down one per cycle.

Only the bench scenarios can show the rest:
- the complete command order and arguments for each card-type pattern;
- the measured 1 ms and 200 us spacings;
- the acceptance of a card that becomes ready on the 300th try;
- the rejection boundaries for access mode and spec version;
- the error code and width fall-back left behind when a failure is injected at a chosen step.

// File: rtl/mmc_mount_pkg.sv
package mmc_mount_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_CLK_SETTLE, ST_RESET_CMD, ST_RESET_GAP, ST_OP_COND, ST_OP_GAP,
        ST_GET_ID, ST_SET_ADDR, ST_GET_CSD, ST_SELECT, ST_BLKLEN, ST_READ_EXT,
        ST_HS_SWITCH, ST_HS_STATUS, ST_BW_SWITCH, ST_BW_STATUS, ST_BW_REREAD,
        ST_MOUNTED, ST_FAILED
    } mnt_state_e;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0, ERR_STATE = 3'd1, ERR_CMD = 3'd2,
        ERR_TIMEOUT = 3'd3, ERR_ACCESS = 3'd4, ERR_ILLEGAL = 3'd5
    } mnt_err_e;

    typedef enum logic [1:0] {
        CLK_400K = 2'd0, CLK_20M = 2'd1, CLK_26M = 2'd2, CLK_52M = 2'd3
    } clk_req_e;

    // switch argument: write-byte access, register byte 185 (timing) / 183 (width)
    localparam logic [31:0] SW_HS_ARG  = 32'h03B9_0100;
    localparam logic [31:0] SW_BW_BASE = 32'h03B7_0000;
    localparam logic [31:0] BLOCK_LEN  = 32'd512;

endpackage

// File: rtl/mmc_wait_timer.sv
module mmc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0) && !load;

    // R3: each armed wait decrements by exactly one per cycle
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mmc_resp_decode.sv
module mmc_resp_decode
    import mmc_mount_pkg::*;
#(
    parameter int MIN_SPEC = 4
) (
    input  logic [127:0] resp,
    input  logic [7:0]   card_type,
    output logic         ocr_ready,
    output logic         ocr_sector,
    output logic         spec_ok,
    output logic         hs_capable,
    output clk_req_e     fast_clk
);
    logic unused_bits;
    assign unused_bits = ^{resp[127:126], resp[121:32], resp[28:0], card_type[7:2]};

    assign ocr_ready  = resp[31];
    assign ocr_sector = (resp[30:29] == 2'b10);
    assign spec_ok    = ({28'd0, resp[125:122]} >= MIN_SPEC);
    assign hs_capable = |card_type[1:0];

    always_comb begin
        if (card_type[1])      fast_clk = CLK_52M;
        else if (card_type[0]) fast_clk = CLK_26M;
        else                   fast_clk = CLK_20M;
    end
endmodule

// File: rtl/mmc_mount_fsm.sv
module mmc_mount_fsm
    import mmc_mount_pkg::*;
#(
    parameter int          CLK_HZ    = 200_000_000,
    parameter int          RETRY_MAX = 300,
    parameter logic [15:0] RCA       = 16'h0001,
    parameter logic [31:0] HOST_OCR  = 32'h40FF_8080,
    parameter logic [1:0]  BW_CODE   = 2'd2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         host_init,
    input  logic         card_pwr,
    input  logic         eng_busy,
    output logic         cmd_start,
    output logic [5:0]   cmd_index,
    output logic [31:0]  cmd_arg,
    output logic         cmd_data,
    input  logic         cmd_done,
    input  logic         cmd_err,
    input  logic [127:0] resp,
    input  logic [7:0]   ext_card_type,
    output logic         clk_en,
    output logic [1:0]   clk_req,
    output logic [1:0]   bus_width,
    output logic         hs_timing,
    output logic         busy,
    output logic         mount_ok,
    output logic         mount_fail,
    output logic [2:0]   err_code
);
    localparam int MS_CYC  = (CLK_HZ / 1000 > 1) ? CLK_HZ / 1000 : 2;
    localparam int GAP_CYC = (CLK_HZ / 5000 > 1) ? CLK_HZ / 5000 : 2;
    localparam int TMR_W   = $clog2(MS_CYC + 1);
    localparam int TRY_W   = $clog2(RETRY_MAX + 1);
    localparam logic [31:0] RCA_ARG = {RCA, 16'h0000};

    mnt_state_e state_q, state_d;
    mnt_err_e   err_q, err_d;
    clk_req_e   clk_req_q, clk_req_d;
    logic       sent_q, sent_d, clk_en_q, clk_en_d, hs_q, hs_d;
    logic [1:0] bw_q, bw_d;
    logic [TRY_W-1:0] tries_q, tries_d;
    logic       is_cmd, cmd_ok, cmd_bad, fail;
    mnt_err_e   fail_code;
    logic       tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    logic       ocr_ready, ocr_sector, spec_ok, hs_capable;
    clk_req_e   fast_clk;

    mmc_wait_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    mmc_resp_decode #(.MIN_SPEC(4)) u_decode (
        .resp(resp), .card_type(ext_card_type), .ocr_ready(ocr_ready),
        .ocr_sector(ocr_sector), .spec_ok(spec_ok), .hs_capable(hs_capable),
        .fast_clk(fast_clk)
    );

    // command presented by each issuing state
    always_comb begin
        is_cmd    = 1'b1;
        cmd_index = 6'd0;
        cmd_arg   = 32'd0;
        cmd_data  = 1'b0;
        unique case (state_q)
            ST_RESET_CMD: cmd_index = 6'd0;
            ST_OP_COND:   begin cmd_index = 6'd1;  cmd_arg = HOST_OCR; end
            ST_GET_ID:    cmd_index = 6'd2;
            ST_SET_ADDR:  begin cmd_index = 6'd3;  cmd_arg = RCA_ARG; end
            ST_GET_CSD:   begin cmd_index = 6'd9;  cmd_arg = RCA_ARG; end
            ST_SELECT:    begin cmd_index = 6'd7;  cmd_arg = RCA_ARG; end
            ST_BLKLEN:    begin cmd_index = 6'd16; cmd_arg = BLOCK_LEN; end
            ST_READ_EXT,
            ST_BW_REREAD: begin cmd_index = 6'd8;  cmd_data = 1'b1; end
            ST_HS_SWITCH: begin cmd_index = 6'd6;  cmd_arg = SW_HS_ARG; end
            ST_BW_SWITCH: begin cmd_index = 6'd6;  cmd_arg = SW_BW_BASE | {16'd0, 6'd0, BW_CODE, 8'd0}; end
            ST_HS_STATUS,
            ST_BW_STATUS: begin cmd_index = 6'd13; cmd_arg = RCA_ARG; end
            default:      is_cmd = 1'b0;
        endcase
    end

    assign cmd_start = is_cmd && !sent_q;
    assign cmd_ok    = is_cmd && sent_q && cmd_done && !cmd_err;
    assign cmd_bad   = is_cmd && sent_q && cmd_done && cmd_err;

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q; err_d = err_q; clk_req_d = clk_req_q; clk_en_d = clk_en_q;
        hs_d = hs_q; bw_d = bw_q; tries_d = tries_q;
        sent_d = cmd_start ? 1'b1 : (cmd_done ? 1'b0 : sent_q);
        tmr_load = 1'b0; tmr_val = TMR_W'(MS_CYC - 1);
        fail = cmd_bad; fail_code = ERR_CMD;
        unique case (state_q)
            ST_IDLE, ST_MOUNTED, ST_FAILED: if (start) begin
                if (!host_init || !card_pwr || eng_busy) begin
                    state_d = ST_FAILED; err_d = ERR_STATE;
                end else begin
                    state_d = ST_CLK_SETTLE; err_d = ERR_NONE; clk_req_d = CLK_400K;
                    clk_en_d = 1'b1; hs_d = 1'b0; bw_d = 2'd0; tries_d = '0;
                    tmr_load = 1'b1;
                end
            end
            ST_CLK_SETTLE: if (tmr_done) state_d = ST_RESET_CMD;
            ST_RESET_CMD: if (cmd_ok) begin
                state_d = ST_RESET_GAP; tmr_load = 1'b1; tmr_val = TMR_W'(GAP_CYC - 1);
            end
            ST_RESET_GAP, ST_OP_GAP: if (tmr_done) state_d = ST_OP_COND;
            ST_OP_COND: if (cmd_ok) begin
                tries_d = tries_q + 1'b1;
                if (ocr_ready) begin
                    if (ocr_sector) state_d = ST_GET_ID;
                    else begin fail = 1'b1; fail_code = ERR_ACCESS; end
                end else if (tries_q + 1'b1 >= TRY_W'(RETRY_MAX)) begin
                    fail = 1'b1; fail_code = ERR_TIMEOUT;
                end else begin
                    state_d = ST_OP_GAP; tmr_load = 1'b1;
                end
            end
            ST_GET_ID:   if (cmd_ok) state_d = ST_SET_ADDR;
            ST_SET_ADDR: if (cmd_ok) state_d = ST_GET_CSD;
            ST_GET_CSD:  if (cmd_ok) begin
                if (spec_ok) state_d = ST_SELECT;
                else begin fail = 1'b1; fail_code = ERR_ILLEGAL; end
            end
            ST_SELECT:   if (cmd_ok) begin state_d = ST_BLKLEN; clk_req_d = CLK_20M; end
            ST_BLKLEN:   if (cmd_ok) state_d = ST_READ_EXT;
            ST_READ_EXT: if (cmd_ok) state_d = hs_capable ? ST_HS_SWITCH : ST_HS_STATUS;
            ST_HS_SWITCH: if (cmd_ok) begin
                state_d = ST_HS_STATUS; hs_d = 1'b1; clk_req_d = fast_clk;
            end
            ST_HS_STATUS: if (cmd_ok) state_d = ST_BW_SWITCH;
            ST_BW_SWITCH: begin
                if (cmd_ok)  begin state_d = ST_BW_STATUS; bw_d = BW_CODE; end
                if (cmd_bad) bw_d = 2'd0;
            end
            ST_BW_STATUS: if (cmd_ok) state_d = ST_BW_REREAD;
            ST_BW_REREAD: if (cmd_ok) state_d = ST_MOUNTED;
            default:      state_d = ST_IDLE;
        endcase
        if (fail) begin
            state_d = ST_FAILED; err_d = fail_code; clk_en_d = 1'b0; sent_d = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; err_q <= ERR_NONE; clk_req_q <= CLK_400K;
            clk_en_q <= 1'b0; hs_q <= 1'b0; bw_q <= 2'd0; tries_q <= '0; sent_q <= 1'b0;
        end else begin
            state_q <= state_d; err_q <= err_d; clk_req_q <= clk_req_d;
            clk_en_q <= clk_en_d; hs_q <= hs_d; bw_q <= bw_d; tries_q <= tries_d; sent_q <= sent_d;
        end
    end

    assign clk_en     = clk_en_q;
    assign clk_req    = clk_req_q;
    assign bus_width  = bw_q;
    assign hs_timing  = hs_q;
    assign err_code   = err_q;
    assign mount_ok   = (state_q == ST_MOUNTED);
    assign mount_fail = (state_q == ST_FAILED);
    assign busy       = !(state_q inside {ST_IDLE, ST_MOUNTED, ST_FAILED});

    assert_state_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && eng_busy) |=> (mount_fail && err_code == 3'd1 && !cmd_start));
    assert_slow_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_index == 6'd1) |-> (clk_en && clk_req == 2'd0));
    assert_try_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q <= TRY_W'(RETRY_MAX));
    assert_hold_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_q && !cmd_done) |=> ($stable(cmd_index) && $stable(cmd_arg)));
    assert_hs_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_timing |-> (clk_req != 2'd0));
    assert_width_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_width == 2'd0) || (bus_width == BW_CODE));
    assert_fail_clk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mount_fail && err_code != 3'd1) |-> !clk_en);
endmodule

// File: tb/mmc_mount_fsm_tb.sv
`timescale 1ns/1ps
module mmc_mount_fsm_tb;
    localparam int CLK_HZ = 50_000;
    localparam int MS     = CLK_HZ / 1000;
    localparam int GAP    = CLK_HZ / 5000;
    localparam logic [15:0] RCA = 16'h00A5;
    localparam logic [31:0] OCR = 32'h40FF_8080;
    localparam logic [31:0] RCAA = {RCA, 16'h0};

    logic clk = 0, rst_n = 0, start = 0, host_init = 1, card_pwr = 1, eng_busy = 0;
    logic cmd_done = 0, cmd_err = 0;
    logic [127:0] resp = '0;
    logic [7:0] ext_card_type = 0;
    logic cmd_start, cmd_data, clk_en, hs_timing, busy, mount_ok, mount_fail;
    logic [5:0] cmd_index; logic [31:0] cmd_arg;
    logic [1:0] clk_req, bus_width; logic [2:0] err_code;

    always #2.5 clk = ~clk;

    mmc_mount_fsm #(.CLK_HZ(CLK_HZ), .RETRY_MAX(300), .RCA(RCA), .HOST_OCR(OCR), .BW_CODE(2'd2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .host_init(host_init), .card_pwr(card_pwr),
        .eng_busy(eng_busy), .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_err(cmd_err), .resp(resp),
        .ext_card_type(ext_card_type), .clk_en(clk_en), .clk_req(clk_req), .bus_width(bus_width),
        .hs_timing(hs_timing), .busy(busy), .mount_ok(mount_ok), .mount_fail(mount_fail),
        .err_code(err_code));

    int checks = 0, fails = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // engine model configuration and log
    int cfg_polls = 0, cfg_fail = -1, n_cmds = 0, n_op = 0;
    logic [1:0] cfg_acc = 2'b10; logic [3:0] cfg_spec = 4'd4;
    logic [5:0] idx_log[0:511]; logic [31:0] arg_log[0:511]; logic dat_log[0:511];
    logic [1:0] ck_log[0:511]; logic cke_log[0:511];
    longint st_log[0:511], dn_log[0:511], start_cyc = 0;
    logic [5:0] exp_idx[0:511]; logic [31:0] exp_arg[0:511]; int exp_n;

    initial begin
        forever begin
            if (!cmd_start) begin @(posedge clk); #1; end
            else begin
                idx_log[n_cmds] = cmd_index; arg_log[n_cmds] = cmd_arg; dat_log[n_cmds] = cmd_data;
                ck_log[n_cmds] = clk_req; cke_log[n_cmds] = clk_en; st_log[n_cmds] = cyc;
                repeat (3) begin @(posedge clk); #1; end
                resp = '0;
                if (idx_log[n_cmds] == 6'd1) begin
                    n_op++;
                    resp[31] = (cfg_polls >= 0) && (n_op > cfg_polls);
                    resp[30:29] = cfg_acc;
                end
                if (idx_log[n_cmds] == 6'd9) resp[125:122] = cfg_spec;
                cmd_err = (n_cmds == cfg_fail);
                dn_log[n_cmds] = cyc;
                n_cmds++;
                cmd_done = 1;
                @(posedge clk); #1;
                cmd_done = 0; cmd_err = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic add_exp(input logic [5:0] i, input logic [31:0] a);
        exp_idx[exp_n] = i; exp_arg[exp_n] = a; exp_n++;
    endtask

    task automatic build_exp(input int polls, input logic [7:0] ct);
        exp_n = 0;
        add_exp(0, 0);
        for (int k = 0; k <= polls; k++) add_exp(1, OCR);
        add_exp(2, 0); add_exp(3, RCAA); add_exp(9, RCAA); add_exp(7, RCAA);
        add_exp(16, 512); add_exp(8, 0);
        if (ct[1] | ct[0]) add_exp(6, 32'h03B9_0100);
        add_exp(13, RCAA); add_exp(6, 32'h03B7_0200); add_exp(13, RCAA); add_exp(8, 0);
    endtask

    task automatic cmp_seq(input string req, input int upto);
        int bad = -1;
        for (int k = 0; k < upto; k++)
            if (bad < 0 && (idx_log[k] != exp_idx[k] || arg_log[k] != exp_arg[k])) bad = k;
        check(bad < 0, req, "command order/argument mismatch at step",
              (bad < 0) ? 0 : {idx_log[bad], arg_log[bad]},
              (bad < 0) ? 0 : {exp_idx[bad], exp_arg[bad]});
    endtask

    task automatic run(input int polls, input logic [1:0] acc, input logic [3:0] spec,
                       input logic [7:0] ct, input int fail_at);
        int guard = 0;
        cfg_polls = polls; cfg_acc = acc; cfg_spec = spec; ext_card_type = ct; cfg_fail = fail_at;
        n_cmds = 0; n_op = 0;
        start = 1; start_cyc = cyc;
        @(posedge clk); #1; start = 0;
        while (busy && guard < 40000) begin @(posedge clk); #1; guard++; end
        check(guard < 40000, "R12", "attempt did not finish", guard, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        fails++; checks++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R12 reset state
        check(!busy && !mount_ok && !mount_fail && !clk_en && !cmd_start && bus_width == 0,
              "R12", "reset outputs", {busy, mount_ok, mount_fail, clk_en, cmd_start, bus_width}, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R1 precondition sweep
        for (int c = 0; c < 8; c++) begin
            if (c != 3'b110) begin
                host_init = c[2]; card_pwr = c[1]; eng_busy = c[0];
                run(0, 2'b10, 4, 0, -1);
                check(mount_fail && err_code == 1 && n_cmds == 0 && !clk_en, "R1",
                      "refused start", {err_code, 8'(n_cmds)}, {3'd1, 8'd0});
            end
        end
        host_init = 1; card_pwr = 1; eng_busy = 0;

        // R9 R10 R6 card-type sweep
        for (int t = 0; t < 4; t++) begin
            logic [1:0] ek;
            run(0, 2'b10, 4, 8'(t), -1);
            build_exp(0, 8'(t));
            ek = (t >= 2) ? 2'd3 : (t == 1) ? 2'd2 : 2'd1;
            check(mount_ok && err_code == 0 && n_cmds == exp_n, "R10", "mount completes",
                  n_cmds, exp_n);
            cmp_seq("R6", exp_n);
            check(clk_req == ek && clk_en, "R9", "final clock request", clk_req, ek);
            check(hs_timing == (t != 0), "R9", "high-speed flag", hs_timing, t != 0);
            check(bus_width == 2, "R10", "bus width code", bus_width, 2);
        end

        // R2 R3 R8 timing and clock snapshots (last run: card type 3)
        check(st_log[0] - start_cyc >= MS, "R2", "1 ms before first command",
              st_log[0] - start_cyc, MS);
        check(cke_log[0] && ck_log[0] == 0, "R2", "slow clock at command 0", ck_log[0], 0);
        check(st_log[1] - dn_log[0] >= GAP, "R3", "200 us gap before command 1",
              st_log[1] - dn_log[0], GAP);
        check(ck_log[6] == 1, "R8", "20 MHz request at command 16", ck_log[6], 1);
        check(dat_log[7] && !dat_log[6] && !dat_log[0], "R8", "data flag only on command 8",
              {dat_log[7], dat_log[6], dat_log[0]}, 3'b100);

        // R3 R4 retries with spacing
        run(5, 2'b10, 4, 8'h01, -1);
        build_exp(5, 8'h01);
        check(mount_ok && n_cmds == exp_n, "R4", "ready after 6 tries", n_cmds, exp_n);
        cmp_seq("R4", exp_n);
        begin
            longint mn = 1000000;
            for (int k = 2; k <= 6; k++)
                if (st_log[k] - dn_log[k-1] < mn) mn = st_log[k] - dn_log[k-1];
            check(mn >= MS, "R3", "spacing between command 1 tries", mn, MS);
        end

        // R4 boundary: ready on the last allowed try
        run(299, 2'b10, 4, 8'h00, -1);
        check(mount_ok && n_op == 300, "R4", "ready on try 300 accepted", n_op, 300);

        // R4 R11 never ready
        run(-1, 2'b10, 4, 8'h00, -1);
        check(mount_fail && err_code == 3 && n_op == 300 && n_cmds == 301, "R4",
              "timeout after 300 tries", {err_code, 16'(n_op)}, {3'd3, 16'd300});
        check(!clk_en, "R11", "clock stopped after timeout", clk_en, 0);

        // R5 access mode
        for (int a = 0; a < 4; a++) begin
            if (a != 2) begin
                run(0, 2'(a), 4, 8'h00, -1);
                check(mount_fail && err_code == 4 && n_cmds == 2 && !clk_en, "R5",
                      "non-sector access rejected", err_code, 4);
            end
        end

        // R7 spec version boundary
        run(0, 2'b10, 4'd3, 8'h00, -1);
        check(mount_fail && err_code == 5 && n_cmds == 5 && !clk_en, "R7", "spec 3 rejected",
              {err_code, 8'(n_cmds)}, {3'd5, 8'd5});
        run(0, 2'b10, 4'd4, 8'h00, -1);
        check(mount_ok, "R7", "spec 4 accepted", mount_ok, 1);

        // R11 command error during identification
        run(0, 2'b10, 4, 8'h00, 2);
        check(mount_fail && err_code == 2 && n_cmds == 3 && !clk_en, "R11", "error at command 2",
              {err_code, 8'(n_cmds)}, {3'd2, 8'd3});

        // R11 error on the high-speed switch
        run(0, 2'b10, 4, 8'h02, 8);
        check(mount_fail && err_code == 2 && n_cmds == 9 && !clk_en && !hs_timing, "R11",
              "error at high-speed switch", {err_code, 8'(n_cmds), hs_timing}, {3'd2, 8'd9, 1'b0});

        // R10 bus-width switch failure falls back to 1-bit
        run(0, 2'b10, 4, 8'h00, 9);
        check(mount_fail && err_code == 2 && n_cmds == 10 && bus_width == 0 && !clk_en, "R10",
              "width switch failure", {err_code, bus_width}, {3'd2, 2'd0});

        // R12 busy is low once resting
        check(!busy, "R12", "idle after failure", busy, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule